// File: doc/BRIEF.md
# Instruction Dispatch Steering Unit

This unit sits between rename and the issue-side queues of an out-of-order core. It accepts a group of up to `SLOTS` renamed instructions through a valid/ready handshake. It then visits the group one slot per cycle, lowest slot first. For each instruction it decides where the instruction goes: the issue queue, the separate non-speculative insert port of the issue queue, the load queue, or the store queue. A no-op instead only advances the issue-queue tail, with its completion marks set. Squashed instructions are dropped.

When the issue queue reports full on an instruction that is still live, the walk ends at once. The unit pulses a block request, holds a stall toward rename until the queue has room, and counts the event. Six saturating counters record how many instructions went to each path. The queues themselves are outside the block.

States: `ST_IDLE` (ready for a group), `ST_WALK` (one slot per cycle) and `ST_HOLD` (stalled after a full stop). Transitions: IDLE to WALK when a group is accepted. WALK to IDLE when the last valid slot is handled or the group has zero slots. WALK to HOLD when a live slot meets a full queue. HOLD to IDLE when the full indication drops.

Top module: `dispatch_steer`

## Requirements
- R1: `grp_ready` is 1 only in ST_IDLE. After a group is accepted, slot k is presented in the (k+1)-th cycle after the accepting edge, on `out_tag` and the write strobes. Slots are visited in order from slot 0, one per cycle.
- R2: A slot whose squash bit is 1 produces no strobe and increments `cnt_squash`. This holds even when `iq_full` is 1, and the walk continues.
- R3: If `iq_full` is 1 on a slot that is not squashed, that slot and every later slot produce no strobe. `block_req` and `done` pulse in that cycle, `cnt_full` increments, and the state moves to ST_HOLD. In ST_HOLD, `stall_req` stays 1 and `grp_ready` stays 0 until `iq_full` is 0, and the unit is ready one cycle later.
- R4: A load raises `ldq_wr` and `iq_wr` together, and increments `cnt_load` and `cnt_disp`.
- R5: A store raises `stq_wr` and `iq_wr` together, and increments `cnt_store` and `cnt_disp`.
- R6: A non-speculative instruction raises only `nsp_wr`, with `mark_commit`, and increments `cnt_nspec`.
- R7: A no-op raises only `tail_adv`, with `mark_issued`, `mark_executed` and `mark_commit`. It changes no counter.
- R8: Classification priority is fixed: squashed, then issue queue full, then load, then store, then non-speculative, then no-op, then normal.
- R9: A normal instruction, with no flag set, raises only `iq_wr` and increments `cnt_disp`.
- R10: `done` pulses in the cycle the last valid slot is handled, or at a stop. A group with `grp_count` 0 gives `done` in its first walk cycle with no strobe. A count above `SLOTS` is treated as `SLOTS`.
- R11: Each counter is `CNT_W` bits wide (default 32), is cleared by reset, increments by at most one per cycle, and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| grp_valid | input | 1 | A group is offered |
| grp_ready | output | 1 | Unit can accept a group |
| grp_count | input | $clog2(SLOTS+1) | Number of valid slots |
| grp_tag | input | SLOTS*TAG_W | Per-slot tags, slot 0 in the low bits |
| grp_squash | input | SLOTS | Per-slot squashed flag |
| grp_load | input | SLOTS | Per-slot load flag |
| grp_store | input | SLOTS | Per-slot store flag |
| grp_nspec | input | SLOTS | Per-slot non-speculative flag |
| grp_nop | input | SLOTS | Per-slot no-op flag |
| iq_full | input | 1 | Issue queue has no free entry |
| out_tag | output | TAG_W | Tag of the slot being steered |
| iq_wr | output | 1 | Insert into issue queue |
| nsp_wr | output | 1 | Insert through non-speculative port |
| ldq_wr | output | 1 | Insert into load queue |
| stq_wr | output | 1 | Insert into store queue |
| tail_adv | output | 1 | Advance issue-queue tail only (no-op) |
| mark_issued | output | 1 | Instruction marked issued |
| mark_executed | output | 1 | Instruction marked executed |
| mark_commit | output | 1 | Instruction marked ready to commit |
| block_req | output | 1 | Pulse: dispatch stopped on full queue |
| stall_req | output | 1 | Stall toward rename |
| done | output | 1 | Pulse: group finished or stopped |
| cnt_disp | output | CNT_W | Issue-queue dispatches (load, store, normal) |
| cnt_squash | output | CNT_W | Squashed instructions dropped |
| cnt_full | output | CNT_W | Full-queue stop events |
| cnt_load | output | CNT_W | Loads dispatched |
| cnt_store | output | CNT_W | Stores dispatched |
| cnt_nspec | output | CNT_W | Non-speculative instructions dispatched |

## Verification
The hardest case to reach is a full stop in the middle of a group, with a squashed slot just before the stopping slot while the queue is already full. The bench changes `iq_full` between clock edges, at exact slot positions of the walk. This shows that the squashed slot is still dropped without a stop, that the next live slot stops the walk, and that the remaining slot never appears. Counter saturation is reached by building the unit with a 4-bit counter width and sending enough squashed groups to pass the limit.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_HOLD} dstate_e;
    typedef enum logic [2:0] {
        K_DROP, K_FULL, K_LOAD, K_STORE, K_NSPEC, K_NOP, K_NORM
    } kind_e;
    localparam int NCNT     = 6;
    localparam int CI_DISP  = 0;
    localparam int CI_SQ    = 1;
    localparam int CI_FULL  = 2;
    localparam int CI_LOAD  = 3;
    localparam int CI_STORE = 4;
    localparam int CI_NSPEC = 5;
endpackage

// File: rtl/dsteer_classify.sv
module dsteer_classify
    import dsteer_pkg::*;
(
    input  logic  sq,
    input  logic  ld,
    input  logic  st,
    input  logic  ns,
    input  logic  nop,
    input  logic  full,
    output kind_e kind
);
    // fixed priority order
    always_comb begin
        if (sq)        kind = K_DROP;
        else if (full) kind = K_FULL;
        else if (ld)   kind = K_LOAD;
        else if (st)   kind = K_STORE;
        else if (ns)   kind = K_NSPEC;
        else if (nop)  kind = K_NOP;
        else           kind = K_NORM;
    end
endmodule

// File: rtl/dsteer_satcnt.sv
module dsteer_satcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (inc && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt = cnt_q;

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV) |=> (cnt_q == MAXV));
    // R11
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dispatch_steer.sv
module dispatch_steer
    import dsteer_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int TAG_W = 8,
    parameter int CNT_W = 32,
    localparam int IW = $clog2(SLOTS + 1),
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grp_valid,
    output logic               grp_ready,
    input  logic [IW-1:0]      grp_count,
    input  logic [SLOTS*TAG_W-1:0] grp_tag,
    input  logic [SLOTS-1:0]   grp_squash,
    input  logic [SLOTS-1:0]   grp_load,
    input  logic [SLOTS-1:0]   grp_store,
    input  logic [SLOTS-1:0]   grp_nspec,
    input  logic [SLOTS-1:0]   grp_nop,
    input  logic               iq_full,
    output logic [TAG_W-1:0]   out_tag,
    output logic               iq_wr,
    output logic               nsp_wr,
    output logic               ldq_wr,
    output logic               stq_wr,
    output logic               tail_adv,
    output logic               mark_issued,
    output logic               mark_executed,
    output logic               mark_commit,
    output logic               block_req,
    output logic               stall_req,
    output logic               done,
    output logic [CNT_W-1:0]   cnt_disp,
    output logic [CNT_W-1:0]   cnt_squash,
    output logic [CNT_W-1:0]   cnt_full,
    output logic [CNT_W-1:0]   cnt_load,
    output logic [CNT_W-1:0]   cnt_store,
    output logic [CNT_W-1:0]   cnt_nspec
);
    localparam logic [IW-1:0] SLOTS_V = IW'(SLOTS);

    dstate_e                state_q, state_d;
    logic [IW-1:0]          idx_q, idx_d, len_q;
    logic [SLOTS*TAG_W-1:0] tag_q;
    logic [SLOTS-1:0]       sq_q, ld_q, st_q, ns_q, nop_q;
    logic                   have;
    logic [SW-1:0]          sel;
    kind_e                  kind;
    logic [NCNT-1:0]        inc;
    logic [CNT_W-1:0]       cnt_bus [NCNT];

    assign have = (state_q == ST_WALK) && (idx_q < len_q);
    assign sel  = have ? idx_q[SW-1:0] : '0;

    dsteer_classify u_cls (
        .sq   (sq_q[sel]),
        .ld   (ld_q[sel]),
        .st   (st_q[sel]),
        .ns   (ns_q[sel]),
        .nop  (nop_q[sel]),
        .full (iq_full),
        .kind (kind)
    );

    // state register and captured group
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            tag_q   <= '0;
            sq_q    <= '0;
            ld_q    <= '0;
            st_q    <= '0;
            ns_q    <= '0;
            nop_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (state_q == ST_IDLE && grp_valid) begin
                len_q <= (grp_count > SLOTS_V) ? SLOTS_V : grp_count;
                tag_q <= grp_tag;
                sq_q  <= grp_squash;
                ld_q  <= grp_load;
                st_q  <= grp_store;
                ns_q  <= grp_nspec;
                nop_q <= grp_nop;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        idx_d         = idx_q;
        grp_ready     = 1'b0;
        iq_wr         = 1'b0;
        nsp_wr        = 1'b0;
        ldq_wr        = 1'b0;
        stq_wr        = 1'b0;
        tail_adv      = 1'b0;
        mark_issued   = 1'b0;
        mark_executed = 1'b0;
        mark_commit   = 1'b0;
        block_req     = 1'b0;
        stall_req     = 1'b0;
        done          = 1'b0;
        inc           = '0;
        unique case (state_q)
            ST_IDLE: begin
                grp_ready = 1'b1;
                if (grp_valid) begin
                    state_d = ST_WALK;
                    idx_d   = '0;
                end
            end
            ST_WALK: begin
                if (!have) begin
                    done    = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    unique case (kind)
                        K_DROP:  inc[CI_SQ] = 1'b1;
                        K_FULL: begin
                            block_req     = 1'b1;
                            stall_req     = 1'b1;
                            inc[CI_FULL]  = 1'b1;
                        end
                        K_LOAD: begin
                            ldq_wr = 1'b1;
                            iq_wr  = 1'b1;
                            inc[CI_LOAD] = 1'b1;
                            inc[CI_DISP] = 1'b1;
                        end
                        K_STORE: begin
                            stq_wr = 1'b1;
                            iq_wr  = 1'b1;
                            inc[CI_STORE] = 1'b1;
                            inc[CI_DISP]  = 1'b1;
                        end
                        K_NSPEC: begin
                            nsp_wr      = 1'b1;
                            mark_commit = 1'b1;
                            inc[CI_NSPEC] = 1'b1;
                        end
                        K_NOP: begin
                            tail_adv      = 1'b1;
                            mark_issued   = 1'b1;
                            mark_executed = 1'b1;
                            mark_commit   = 1'b1;
                        end
                        K_NORM: begin
                            iq_wr        = 1'b1;
                            inc[CI_DISP] = 1'b1;
                        end
                        default: ;
                    endcase
                    if (kind == K_FULL) begin
                        done    = 1'b1;
                        state_d = ST_HOLD;
                    end else if (idx_q == len_q - 1'b1) begin
                        done    = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                stall_req = 1'b1;
                if (!iq_full) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign out_tag = tag_q[sel*TAG_W +: TAG_W];

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        dsteer_satcnt #(.CNT_W(CNT_W)) u_c (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[c]),
            .cnt   (cnt_bus[c])
        );
    end
    assign cnt_disp   = cnt_bus[CI_DISP];
    assign cnt_squash = cnt_bus[CI_SQ];
    assign cnt_full   = cnt_bus[CI_FULL];
    assign cnt_load   = cnt_bus[CI_LOAD];
    assign cnt_store  = cnt_bus[CI_STORE];
    assign cnt_nspec  = cnt_bus[CI_NSPEC];

    // R3
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_full |-> !(iq_wr || nsp_wr || ldq_wr || stq_wr || tail_adv));
    // R3
    block_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_req |=> (stall_req && !grp_ready));
    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && grp_ready) |=> !grp_ready);
    // R4
    load_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ldq_wr || stq_wr) |-> iq_wr);
    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !block_req) |=> grp_ready);
    // R8
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ldq_wr, stq_wr, nsp_wr, tail_adv}));
endmodule

// File: tb/sim_dispatch_steer.sv
`timescale 1ns/1ps
module sim_dispatch_steer;
    localparam int SLOTS = 4;
    localparam int TAG_W = 8;
    localparam int CNT_W = 4;
    localparam int IW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_valid = 1'b0;
    logic grp_ready;
    logic [IW-1:0] grp_count = '0;
    logic [SLOTS*TAG_W-1:0] grp_tag = '0;
    logic [SLOTS-1:0] grp_squash = '0, grp_load = '0, grp_store = '0,
                      grp_nspec = '0, grp_nop = '0;
    logic iq_full = 1'b0;
    logic [TAG_W-1:0] out_tag;
    logic iq_wr, nsp_wr, ldq_wr, stq_wr, tail_adv;
    logic mark_issued, mark_executed, mark_commit, block_req, stall_req, done;
    logic [CNT_W-1:0] cnt_disp, cnt_squash, cnt_full, cnt_load, cnt_store, cnt_nspec;

    int tests = 0;
    int fails = 0;
    int e_disp = 0, e_sq = 0, e_full = 0, e_ld = 0, e_st = 0, e_ns = 0;

    always #2.5 clk = ~clk;

    dispatch_steer #(.SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
        .grp_count(grp_count), .grp_tag(grp_tag), .grp_squash(grp_squash),
        .grp_load(grp_load), .grp_store(grp_store), .grp_nspec(grp_nspec),
        .grp_nop(grp_nop), .iq_full(iq_full), .out_tag(out_tag),
        .iq_wr(iq_wr), .nsp_wr(nsp_wr), .ldq_wr(ldq_wr), .stq_wr(stq_wr),
        .tail_adv(tail_adv), .mark_issued(mark_issued),
        .mark_executed(mark_executed), .mark_commit(mark_commit),
        .block_req(block_req), .stall_req(stall_req), .done(done),
        .cnt_disp(cnt_disp), .cnt_squash(cnt_squash), .cnt_full(cnt_full),
        .cnt_load(cnt_load), .cnt_store(cnt_store), .cnt_nspec(cnt_nspec)
    );

    function automatic int sat(input int v);
        return (v > 15) ? 15 : v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // strobe vector: iq,nsp,ldq,stq,tail,iss,exe,cc,blk,done
    function automatic int strobes();
        return {iq_wr, nsp_wr, ldq_wr, stq_wr, tail_adv, mark_issued,
                mark_executed, mark_commit, block_req, done};
    endfunction

    task automatic offer(input int cnt, input logic [31:0] tags,
                         input logic [3:0] sq, input logic [3:0] ld,
                         input logic [3:0] st, input logic [3:0] ns,
                         input logic [3:0] np);
        @(negedge clk);
        grp_valid = 1'b1; grp_count = IW'(cnt); grp_tag = tags;
        grp_squash = sq; grp_load = ld; grp_store = st; grp_nspec = ns; grp_nop = np;
        @(posedge clk);
        @(negedge clk);
        grp_valid = 1'b0;
    endtask

    task automatic check_counters(input string req);
        chk({req, " cnt_disp"},   int'(cnt_disp),   sat(e_disp));
        chk({req, " cnt_squash"}, int'(cnt_squash), sat(e_sq));
        chk({req, " cnt_full"},   int'(cnt_full),   sat(e_full));
        chk({req, " cnt_load"},   int'(cnt_load),   sat(e_ld));
        chk({req, " cnt_store"},  int'(cnt_store),  sat(e_st));
        chk({req, " cnt_nspec"},  int'(cnt_nspec),  sat(e_ns));
    endtask

    task automatic t_reset();
        chk("R1 ready at reset", int'(grp_ready), 1);
        chk("R3 no stall at reset", int'(stall_req), 0);
        chk("R1 no strobes at reset", strobes(), 0);
        check_counters("R11 reset");
    endtask

    task automatic t_normal();
        offer(4, 32'h0D0C0B0A, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        chk("R1 busy while walking", int'(grp_ready), 0);
        for (int k = 0; k < 4; k++) begin
            chk("R1 slot order tag", int'(out_tag), 'h0A + k);
            chk("R9 normal strobes", strobes(), (k == 3) ? 10'b1000000001 : 10'b1000000000);
            @(negedge clk);
        end
        e_disp += 4;
        chk("R10 ready after done", int'(grp_ready), 1);
        check_counters("R9 normal");
    endtask

    task automatic t_mixed();
        // slot0 squashed load, slot1 load, slot2 store, slot3 nspec
        offer(4, 32'h24232221, 4'b0001, 4'b0011, 4'b0100, 4'b1000, 4'h0);
        chk("R2 squashed dropped", strobes(), 10'b0000000000);
        @(negedge clk);
        chk("R4 load strobes", strobes(), 10'b1010000000);
        @(negedge clk);
        chk("R5 store strobes", strobes(), 10'b1001000000);
        @(negedge clk);
        chk("R6 nspec strobes", strobes(), 10'b0100000101);
        chk("R6 nspec tag", int'(out_tag), 'h24);
        @(negedge clk);
        e_sq++; e_ld++; e_st++; e_ns++; e_disp += 2;
        check_counters("R4 R5 R6 mixed");
    endtask

    task automatic t_prio();
        offer(3, 32'h00333231, 4'h0, 4'b0001, 4'b0011, 4'b0111, 4'b0111);
        chk("R8 load beats store/nspec/nop", strobes(), 10'b1010000000);
        @(negedge clk);
        chk("R8 store beats nspec/nop", strobes(), 10'b1001000000);
        @(negedge clk);
        chk("R8 nspec beats nop", strobes(), 10'b0100000101);
        @(negedge clk);
        e_ld++; e_st++; e_ns++; e_disp += 2;
        offer(1, 32'h00000041, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0001);
        chk("R7 nop strobes", strobes(), 10'b0000111101);
        @(negedge clk);
        check_counters("R7 nop no count");
    endtask

    task automatic t_full();
        // slot0 normal, slot1 squashed, slot2 normal (stops), slot3 normal
        offer(4, 32'h54535251, 4'b0010, 4'h0, 4'h0, 4'h0, 4'h0);
        chk("R3 slot0 before full", strobes(), 10'b1000000000);
        @(negedge clk);
        iq_full = 1'b1;
        #0.5;
        chk("R2 squashed under full no stop", strobes(), 10'b0000000000);
        @(negedge clk);
        chk("R3 stop strobes", strobes(), 10'b0000000011);
        chk("R3 stall at stop", int'(stall_req), 1);
        @(negedge clk);
        chk("R3 hold stall", int'(stall_req), 1);
        chk("R3 hold not ready", int'(grp_ready), 0);
        chk("R3 later slot dropped", strobes(), 0);
        @(negedge clk);
        chk("R3 still held", int'(stall_req), 1);
        iq_full = 1'b0;
        @(negedge clk);
        chk("R3 ready after full clears", int'(grp_ready), 1);
        chk("R3 stall released", int'(stall_req), 0);
        e_disp++; e_sq++; e_full++;
        check_counters("R3 full");
    endtask

    task automatic t_empty();
        offer(0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        chk("R10 zero-count done", strobes(), 10'b0000000001);
        @(negedge clk);
        chk("R10 zero-count ready", int'(grp_ready), 1);
        // count above SLOTS clamps to SLOTS
        offer(7, 32'h64636261, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0);
        for (int k = 0; k < 4; k++) begin
            chk("R10 clamped walk done", int'(done), (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R10 clamped ready", int'(grp_ready), 1);
        e_sq += 4;
        check_counters("R10 clamp");
    endtask

    task automatic t_sat();
        for (int g = 0; g < 3; g++) begin
            offer(4, 32'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0);
            repeat (4) @(negedge clk);
            e_sq += 4;
        end
        chk("R11 squash counter saturates", int'(cnt_squash), 15);
        check_counters("R11 saturation");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_mixed();
        t_prio();
        t_full();
        t_empty();
        t_sat();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule